// File: doc/BRIEF.md
# Output Driver Overcurrent Guard with Blanking and Auto-Retry

This block decides, cycle by cycle, whether one line driver of an industrial I/O transceiver may be enabled. It watches a digital overcurrent indication and a thermal-shutdown indication, both produced by analog sensing outside the block. An 8-bit configuration word selects the behaviour. On overcurrent the block can ride out a short blanking window first. After that window it either switches the driver off for a retry interval and then tries again, or it leaves the driver running.

Thermal shutdown always wins. It forces the driver off on the next clock edge, whatever the retry logic is doing, and releases it on the first edge after the thermal indication clears. The block also gives a registered fault flag for the interrupt logic and a gate for a small pull-down current sink. That sink is allowed only while the driver is off and the current-limit field selects the one setting that permits it.

All pins are plain control and status signals. The block has no streaming interface, so no valid/ready handshake applies.

Top module: `ocp_retry_ctrl`

## Requirements
- R1: The configuration word `cfg` has four fields. Bits 7:5 are the current-limit code, bits 4:3 the blanking code, bits 2:1 the retry code, and bit 0 the auto-retry enable (1 = enabled). The fields are read live every cycle.
- R2: During and after reset, with no fault present, `drv_en` = 1, `drv_fault` = 0 and `pd_5ma_en` = 0.
- R3: With auto-retry enabled and blanking code 00, 01 or 10, let N be the selected blanking count. If `oc_det` is sampled high on N+1 consecutive rising edges, starting from the enabled state, `drv_en` goes low after the (N+1)th edge.
- R4: After an overcurrent shutdown, `drv_en` stays low for exactly R clock edges, where R is the selected retry count. It then returns high, whatever `oc_det` does during that time.
- R5: With auto-retry enabled and blanking code 11, the first rising edge that samples `oc_det` high while the driver is enabled turns `drv_en` low.
- R6: If `oc_det` is sampled low before the blanking count expires, the window is abandoned and `drv_en` stays high. A later overcurrent starts a fresh full window.
- R7: With auto-retry disabled, `oc_det` never lowers `drv_en`. Only thermal shutdown can lower it.
- R8: `tsd` sampled high lowers `drv_en` on that edge, from any state, and holds it low for as long as `tsd` stays high. The first edge that samples `tsd` low raises `drv_en` again.
- R9: Clearing the auto-retry enable while the driver is off for a retry raises `drv_en` on the next edge.
- R10: `drv_fault` is a registered copy of (`oc_det` OR `tsd`) as sampled on the previous rising edge.
- R11: `pd_5ma_en` is 1 exactly when `pd_req` = 1, `drv_en` = 0 and `cfg[7:5]` equals the parameter `PD_ILIM_CODE` (default 011). It follows these inputs combinationally.
- R12: Blanking codes 00, 01 and 10 select the parameters `BLANK0`, `BLANK1` and `BLANK2`. Retry codes 00, 01, 10 and 11 select `RETRY0`, `RETRY1`, `RETRY2` and `RETRY3`. All of these counts must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | 8 | Configuration word: current limit, blanking, retry, auto-retry enable |
| oc_det | input | 1 | Overcurrent indication from the sensing circuit |
| tsd | input | 1 | Thermal-shutdown indication |
| pd_req | input | 1 | Request for the small pull-down sink while the driver is off |
| drv_en | output | 1 | Driver enable |
| drv_fault | output | 1 | Registered fault flag for the interrupt logic |
| pd_5ma_en | output | 1 | Pull-down sink enable |

## Verification
The bound checker watches several rules on every cycle:
- thermal shutdown forcing the driver off and releasing it;
- overcurrent never turning the driver off while auto-retry is disabled;
- the immediate shutdown under blanking code 11;
- an abandoned blanking window keeping the driver on;
- the one-cycle fault flag;
- the pull-down never being active while the driver is on.

The exact lengths of the blanking and retry windows for every code pair need the bench scenarios, which count edges from stimulus to output change. So do the mid-retry change of the enable and the gating of the pull-down by the current-limit code.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    ST_ON    = 2'd0,
    ST_BLANK = 2'd1,
    ST_OFF   = 2'd2,
    ST_THERM = 2'd3
  } ocp_state_e;

  // field positions matter: software writes the word as a whole
  typedef struct packed {
    logic [2:0] ilim;
    logic [1:0] blank;
    logic [1:0] retry;
    logic       auto_en;
  } ocp_cfg_t;

  localparam logic [1:0] BLANK_NONE = 2'b11;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ocp_window_lut.sv
module ocp_window_lut
  import ocp_pkg::*;
#(
  parameter int BLANK0 = 4,
  parameter int BLANK1 = 8,
  parameter int BLANK2 = 16,
  parameter int RETRY0 = 6,
  parameter int RETRY1 = 12,
  parameter int RETRY2 = 24,
  parameter int RETRY3 = 48,
  parameter int CNT_W  = 6
) (
  input  ocp_cfg_t         cfg,
  output logic             blank_none,
  output logic [CNT_W-1:0] blank_last,
  output logic [CNT_W-1:0] retry_last
);

  // counters run down to zero, so the terminal value is length - 1
  localparam logic [CNT_W-1:0] BL0 = CNT_W'(BLANK0 - 1);
  localparam logic [CNT_W-1:0] BL1 = CNT_W'(BLANK1 - 1);
  localparam logic [CNT_W-1:0] BL2 = CNT_W'(BLANK2 - 1);
  localparam logic [CNT_W-1:0] RT0 = CNT_W'(RETRY0 - 1);
  localparam logic [CNT_W-1:0] RT1 = CNT_W'(RETRY1 - 1);
  localparam logic [CNT_W-1:0] RT2 = CNT_W'(RETRY2 - 1);
  localparam logic [CNT_W-1:0] RT3 = CNT_W'(RETRY3 - 1);

  assign blank_none = (cfg.blank == BLANK_NONE);

  always_comb begin
    unique case (cfg.blank)
      2'b00:   blank_last = BL0;
      2'b01:   blank_last = BL1;
      2'b10:   blank_last = BL2;
      default: blank_last = '0;
    endcase
  end

  always_comb begin
    unique case (cfg.retry)
      2'b00:   retry_last = RT0;
      2'b01:   retry_last = RT1;
      2'b10:   retry_last = RT2;
      default: retry_last = RT3;
    endcase
  end

endmodule

// File: rtl/ocp_down_cnt.sv
module ocp_down_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ocp_guard_fsm.sv
module ocp_guard_fsm
  import ocp_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oc_det,
  input  logic             tsd,
  input  logic             auto_en,
  input  logic             blank_none,
  input  logic [CNT_W-1:0] blank_last,
  input  logic [CNT_W-1:0] retry_last,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_dec,
  output ocp_state_e       state
);

  ocp_state_e nxt;

  always_comb begin
    nxt      = state;
    cnt_load = 1'b0;
    cnt_val  = blank_last;
    cnt_dec  = 1'b0;
    if (tsd) begin
      nxt = ST_THERM;
    end else begin
      unique case (state)
        ST_ON: begin
          if (oc_det && auto_en) begin
            cnt_load = 1'b1;
            if (blank_none) begin
              nxt     = ST_OFF;
              cnt_val = retry_last;
            end else begin
              nxt     = ST_BLANK;
              cnt_val = blank_last;
            end
          end
        end
        ST_BLANK: begin
          if (!oc_det || !auto_en) begin
            nxt = ST_ON;
          end else if (cnt_zero) begin
            nxt      = ST_OFF;
            cnt_load = 1'b1;
            cnt_val  = retry_last;
          end else begin
            cnt_dec = 1'b1;
          end
        end
        ST_OFF: begin
          if (!auto_en || cnt_zero) nxt = ST_ON;
          else                      cnt_dec = 1'b1;
        end
        default: nxt = ST_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ON;
    else        state <= nxt;
  end

endmodule

// File: rtl/ocp_retry_ctrl.sv
module ocp_retry_ctrl
  import ocp_pkg::*;
#(
  parameter int         BLANK0       = 4,
  parameter int         BLANK1       = 8,
  parameter int         BLANK2       = 16,
  parameter int         RETRY0       = 6,
  parameter int         RETRY1       = 12,
  parameter int         RETRY2       = 24,
  parameter int         RETRY3       = 48,
  parameter logic [2:0] PD_ILIM_CODE = 3'b011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg,
  input  logic       oc_det,
  input  logic       tsd,
  input  logic       pd_req,
  output logic       drv_en,
  output logic       drv_fault,
  output logic       pd_5ma_en
);

  localparam int LONGEST = max_of4(max_of4(BLANK0, BLANK1, BLANK2, 1),
                                   RETRY0, RETRY1, max_of4(RETRY2, RETRY3, 1, 1));
  localparam int CNT_W   = $clog2(LONGEST + 1);

  ocp_cfg_t         cfg_s;
  ocp_state_e       state;
  logic             blank_none;
  logic [CNT_W-1:0] blank_last;
  logic [CNT_W-1:0] retry_last;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_dec;
  logic             cnt_zero;

  assign cfg_s = ocp_cfg_t'(cfg);

  ocp_window_lut #(
    .BLANK0(BLANK0), .BLANK1(BLANK1), .BLANK2(BLANK2),
    .RETRY0(RETRY0), .RETRY1(RETRY1), .RETRY2(RETRY2), .RETRY3(RETRY3),
    .CNT_W (CNT_W)
  ) lut_i (
    .cfg       (cfg_s),
    .blank_none(blank_none),
    .blank_last(blank_last),
    .retry_last(retry_last)
  );

  ocp_down_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(cnt_val),
    .dec     (cnt_dec),
    .zero    (cnt_zero)
  );

  ocp_guard_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .oc_det    (oc_det),
    .tsd       (tsd),
    .auto_en   (cfg_s.auto_en),
    .blank_none(blank_none),
    .blank_last(blank_last),
    .retry_last(retry_last),
    .cnt_zero  (cnt_zero),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .cnt_dec   (cnt_dec),
    .state     (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_fault <= 1'b0;
    else        drv_fault <= oc_det | tsd;
  end

  assign drv_en    = (state == ST_ON) || (state == ST_BLANK);
  assign pd_5ma_en = pd_req && !drv_en && (cfg_s.ilim == PD_ILIM_CODE);

endmodule

// File: rtl/ocp_retry_ctrl_chk.sv
module ocp_retry_ctrl_chk
  import ocp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg,
  input logic       oc_det,
  input logic       tsd,
  input logic       drv_en,
  input logic       drv_fault,
  input logic       pd_5ma_en,
  input ocp_state_e st
);

  assert_thermal_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tsd |=> !drv_en);

  assert_thermal_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_THERM && !tsd) |=> drv_en);

  assert_no_retry_keeps_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[0] && !tsd) |=> drv_en);

  assert_retry_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && !cfg[0] && !tsd) |=> (st == ST_ON));

  assert_immediate_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON && cfg[0] && cfg[4:3] == 2'b11 && oc_det && !tsd) |=> !drv_en);

  assert_blank_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BLANK && !oc_det && !tsd) |=> drv_en);

  assert_fault_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_det || tsd) |=> drv_fault);

  assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_det && !tsd) |=> !drv_fault);

  assert_pd_only_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> !pd_5ma_en);

endmodule

bind ocp_retry_ctrl ocp_retry_ctrl_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg      (cfg),
  .oc_det   (oc_det),
  .tsd      (tsd),
  .drv_en   (drv_en),
  .drv_fault(drv_fault),
  .pd_5ma_en(pd_5ma_en),
  .st       (state)
);

// File: tb/ocp_retry_ctrl_tb_top.sv
`timescale 1ns/100ps
module ocp_retry_ctrl_tb_top;

  localparam int B0 = 2, B1 = 3, B2 = 5;
  localparam int T0 = 2, T1 = 3, T2 = 4, T3 = 6;
  localparam logic [2:0] PDC = 3'b011;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg = 8'h20;
  logic       oc_det = 1'b0;
  logic       tsd = 1'b0;
  logic       pd_req = 1'b0;
  logic       drv_en, drv_fault, pd_5ma_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ocp_retry_ctrl #(
    .BLANK0(B0), .BLANK1(B1), .BLANK2(B2),
    .RETRY0(T0), .RETRY1(T1), .RETRY2(T2), .RETRY3(T3),
    .PD_ILIM_CODE(PDC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .oc_det(oc_det), .tsd(tsd),
    .pd_req(pd_req), .drv_en(drv_en), .drv_fault(drv_fault), .pd_5ma_en(pd_5ma_en)
  );

  // {oc_det, tsd, expected drv_en, expected drv_fault}; cfg 0x21: blank 00, retry 00, auto on
  localparam logic [3:0] TRACE [12] = '{
    4'b0010, 4'b1011, 4'b1011, 4'b1001, 4'b1001, 4'b0010,
    4'b1011, 4'b0010, 4'b1011, 4'b1101, 4'b0101, 4'b0010
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; oc_det = 1'b0; tsd = 1'b0; pd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic int blank_of(input int code);
    case (code)
      0: return B0 + 1;
      1: return B1 + 1;
      2: return B2 + 1;
      default: return 1;
    endcase
  endfunction

  function automatic int retry_of(input int code);
    case (code)
      0: return T0;
      1: return T1;
      2: return T2;
      default: return T3;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R2 reset state
    do_reset();
    check(drv_en == 1'b1, "R2 drv_en", drv_en, 1);
    check(drv_fault == 1'b0, "R2 drv_fault", drv_fault, 0);
    check(pd_5ma_en == 1'b0, "R2 pd_5ma_en", pd_5ma_en, 0);

    // trace table: R3 R4 R6 R8 R10
    cfg = 8'h21;
    for (int i = 0; i < 12; i++) begin
      oc_det = TRACE[i][3];
      tsd    = TRACE[i][2];
      @(negedge clk);
      check(drv_en == TRACE[i][1], "R3/R6 trace drv_en", drv_en, TRACE[i][1]);
      check(drv_fault == TRACE[i][0], "R10 trace drv_fault", drv_fault, TRACE[i][0]);
    end

    // R1 R3 R4 R5 R12: every blanking and retry code pair
    do_reset();
    for (int b = 0; b < 4; b++) begin
      for (int r = 0; r < 4; r++) begin
        int cnt;
        cfg = {3'b001, 2'(b), 2'(r), 1'b1};
        oc_det = 1'b1;
        cnt = 0;
        while (cnt < 100) begin
          @(negedge clk);
          cnt++;
          if (!drv_en) break;
        end
        check(cnt == blank_of(b), "R3/R5/R12 edges to trip", cnt, blank_of(b));
        oc_det = 1'b0;
        cnt = 0;
        while (cnt < 100) begin
          @(negedge clk);
          cnt++;
          if (drv_en) break;
        end
        check(cnt == retry_of(r), "R4/R12 retry edges", cnt, retry_of(r));
        @(negedge clk);
      end
    end

    // R7 auto-retry disabled: overcurrent never turns driver off
    do_reset();
    cfg = 8'h20;
    oc_det = 1'b1;
    begin
      bit stayed = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!drv_en) stayed = 1'b0;
      end
      check(stayed, "R7 driver held on", stayed, 1);
      check(drv_fault == 1'b1, "R10 fault with oc", drv_fault, 1);
    end
    oc_det = 1'b0;

    // R9 clearing auto-retry during retry off time
    do_reset();
    cfg = 8'h3F;
    oc_det = 1'b1;
    @(negedge clk);
    check(drv_en == 1'b0, "R5 immediate trip", drv_en, 0);
    oc_det = 1'b0;
    @(negedge clk);
    check(drv_en == 1'b0, "R4 still in retry", drv_en, 0);
    cfg = 8'h3E;
    @(negedge clk);
    check(drv_en == 1'b1, "R9 cancel retry", drv_en, 1);

    // R8 thermal during retry holds the driver off past the retry time
    do_reset();
    cfg = 8'h3F;
    oc_det = 1'b1;
    @(negedge clk);
    oc_det = 1'b0;
    tsd = 1'b1;
    repeat (T3 + 4) @(negedge clk);
    check(drv_en == 1'b0, "R8 thermal hold", drv_en, 0);
    tsd = 1'b0;
    @(negedge clk);
    check(drv_en == 1'b1, "R8 thermal release", drv_en, 1);

    // R11 pull-down gating
    do_reset();
    cfg = {PDC, 2'b11, 2'b11, 1'b1};
    pd_req = 1'b1;
    #1;
    check(pd_5ma_en == 1'b0, "R11 pd with driver on", pd_5ma_en, 0);
    @(negedge clk);
    oc_det = 1'b1;
    @(negedge clk);
    oc_det = 1'b0;
    check(pd_5ma_en == 1'b1, "R11 pd when off", pd_5ma_en, 1);
    cfg = {3'b001, 2'b11, 2'b11, 1'b1};
    #1;
    check(pd_5ma_en == 1'b0, "R11 pd wrong limit code", pd_5ma_en, 0);
    cfg = {PDC, 2'b11, 2'b11, 1'b1};
    pd_req = 1'b0;
    #1;
    check(pd_5ma_en == 1'b0, "R11 pd not requested", pd_5ma_en, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule